// File: doc/BRIEF.md
# SPI Command-Decoding Register Slave

This block is the host-facing side of a small network-controller-style device. An external SPI master (mode 3: clock idles high, data captured on the rising edge, changed on the falling edge) sends one command byte after each chip-select assertion. The three upper bits of that byte are an opcode and the five lower bits are an argument. The block decodes the command and reads or updates a banked register file, or streams bytes to and from a buffer RAM through an auto-incrementing pointer. All SPI pins are oversampled by the system clock, so the SPI clock must be several times slower than `clk`.

The register space has 32 addresses. Addresses 0x00 to 0x1A exist separately in each of four banks. Addresses 0x1B to 0x1F are shared by all banks. The two low bits of 0x1F choose the bank that the lower addresses reach. An internal port gives the surrounding logic, or a test bench, direct access to the registers (with an explicit bank) and to the buffer RAM.

Top module: `spi_cmd_slave`

## Requirements
- R1: After `rst_n` is released, `miso` is 0, every register reads 0 (bank 0, pointer 0), and status bit 0 (clock ready, address 0x1D) reads 0 for `RDY_DLY` cycles and 1 after that.
- R2: Opcode 010 (command 0x40 | addr) writes the next byte on MOSI into the addressed register.
- R3: Opcode 000 (command 0x00 | addr) returns the register value on MISO, MSB first, in the byte slot that follows the command.
- R4: Address 0x1F holds the bank number in bits [1:0], reads 0 in bits [7:2], and reaches the same register from every bank. Addresses 0x1B to 0x1F are common to all banks, and 0x00 to 0x1A are banked.
- R5: Opcode 100 (0x80 | addr) ORs the next byte into the register.
- R6: Opcode 101 (0xA0 | addr) clears the register bits that are 1 in the next byte.
- R7: Command 0x3A streams buffer bytes starting at the pointer, one per slot, for as long as chip select stays low. The pointer advances once per delivered byte and wraps from 2^BUF_AW-1 to 0.
- R8: Command 0x7A stores every following MOSI byte at the pointer and advances the pointer after each byte.
- R9: A register read at addresses 0x00 to 0x1A while bank 2 or bank 3 is selected returns one dummy byte 0x00 first, then the value.
- R10: Command 0xFF is a soft reset. It zeroes all registers, the bank bits and the pointer. The clock-ready bit drops to 0 for `RDY_DLY` cycles, buffer contents are kept, and the rest of that transaction is ignored.
- R11: Raising chip select ends any command. Extra bytes after a single-data command are ignored, as are the unused opcode 110 and buffer opcodes with an argument other than 0x1A. The next assertion of chip select expects a new command byte.
- R12: The status register 0x1D is read-only. Writes, bit-set and bit-clear commands leave it unchanged.
- R13: With `int_reg`=1, `int_addr[6:5]` is the bank and `int_addr[4:0]` is the address. With `int_reg`=0, `int_addr` is a buffer address. `int_rdata` follows the address combinationally, and `int_we` writes on the clock edge. An internal register write in the same cycle as an SPI register write is dropped.
- R14: In bank 0, address 0x00 is the pointer's low byte and address 0x01 holds the pointer bits [BUF_AW-1:8] (upper bits read 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock, idles high |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, 0 while deselected |
| int_reg | input | 1 | Internal port space: 1 registers, 0 buffer |
| int_we | input | 1 | Internal port write strobe |
| int_addr | input | BUF_AW | Internal port address |
| int_wdata | input | 8 | Internal port write data |
| int_rdata | output | 8 | Internal port read data |

## Verification
The assertions assume that the SPI pins are quasi-static compared with `clk`: `sck` holds each level for several system cycles, `mosi` settles before the rising edge, and `cs_n` changes only while `sck` is high. The miso-idle property also assumes that `cs_n` is held high during reset. The bench drives every pin on the falling edge of `clk`, holds each SCK phase for eight cycles, and surrounds each chip-select transition with eight idle cycles, so all of these conditions hold throughout.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int BUF_AW  = 11,
  parameter int RDY_DLY = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              int_reg,
  input  logic              int_we,
  input  logic [BUF_AW-1:0] int_addr,
  input  logic [7:0]        int_wdata,
  output logic [7:0]        int_rdata
);

  localparam int BUF_DEPTH = 1 << BUF_AW;
  localparam int PH_W      = BUF_AW - 8;
  localparam int CW        = $clog2(RDY_DLY + 2);
  localparam logic [4:0] A_PTRL = 5'h00;
  localparam logic [4:0] A_PTRH = 5'h01;
  localparam logic [4:0] A_BUF  = 5'h1A;
  localparam logic [4:0] A_COM  = 5'h1B;
  localparam logic [4:0] A_STAT = 5'h1D;
  localparam logic [4:0] A_BANK = 5'h1F;

  typedef enum logic [2:0] {S_CMD, S_DATA, S_DUMMY, S_BRD, S_BWR, S_IGN} st_t;

  logic [7:0]        bank_r [4][32];
  logic [7:0]        mem [BUF_DEPTH];
  logic [1:0]        bank;
  logic [BUF_AW-1:0] ptr;
  logic [BUF_AW-1:0] ptr_nx;
  logic [CW-1:0]     rdy_cnt;
  logic              clk_rdy;

  logic [1:0] cs_s;
  logic [2:0] sck_s;
  logic [1:0] mosi_s;
  logic       cs_act, sck_rise, sck_fall, byte_done;
  logic [2:0] bcnt;
  logic [6:0] rx_sh;
  logic [7:0] rx_byte;
  logic [7:0] tx_sh;
  logic       miso_q;
  st_t        st, nx_st;
  logic [2:0] op_q;
  logic [4:0] arg_q;

  logic [7:0] tx_ld, sreg_wd, cur;
  logic       sreg_we, buf_we, ptr_inc, soft_rst;

  logic       w_en;
  logic [1:0] w_b, w_eb;
  logic [4:0] w_a;
  logic [7:0] w_d;

  assign clk_rdy = (rdy_cnt == '0);
  assign ptr_nx  = ptr + 1'b1;

  function automatic logic [7:0] rd_reg(input logic [1:0] b, input logic [4:0] a);
    logic [1:0] eb;
    eb = (a >= A_COM) ? 2'd0 : b;
    if (a == A_BANK)                      return {6'd0, bank};
    else if (a == A_STAT)                 return {7'd0, clk_rdy};
    else if (eb == 2'd0 && a == A_PTRL)   return ptr[7:0];
    else if (eb == 2'd0 && a == A_PTRH)   return {{(16-BUF_AW){1'b0}}, ptr[BUF_AW-1:8]};
    else                                  return bank_r[eb][a];
  endfunction

  function automatic logic slow_class(input logic [1:0] b, input logic [4:0] a);
    return b[1] && (a < A_COM);
  endfunction

  assign cs_act    = ~cs_s[1];
  assign sck_rise  = sck_s[1] & ~sck_s[2];
  assign sck_fall  = ~sck_s[1] & sck_s[2];
  assign rx_byte   = {rx_sh, mosi_s[1]};
  assign byte_done = cs_act & sck_rise & (bcnt == 3'd7);
  assign miso      = miso_q;

  assign cur = rd_reg(bank, arg_q);

  always_comb begin
    nx_st    = st;
    tx_ld    = 8'h00;
    sreg_we  = 1'b0;
    sreg_wd  = rx_byte;
    buf_we   = 1'b0;
    ptr_inc  = 1'b0;
    soft_rst = 1'b0;
    if (byte_done) begin
      case (st)
        S_CMD: begin
          case (rx_byte[7:5])
            3'b000: begin
              if (slow_class(bank, rx_byte[4:0])) nx_st = S_DUMMY;
              else begin
                tx_ld = rd_reg(bank, rx_byte[4:0]);
                nx_st = S_IGN;
              end
            end
            3'b001: begin
              if (rx_byte[4:0] == A_BUF) begin
                tx_ld = mem[ptr];
                nx_st = S_BRD;
              end else nx_st = S_IGN;
            end
            3'b011: nx_st = (rx_byte[4:0] == A_BUF) ? S_BWR : S_IGN;
            3'b010, 3'b100, 3'b101: nx_st = S_DATA;
            3'b111: begin
              soft_rst = (rx_byte[4:0] == 5'h1F);
              nx_st    = S_IGN;
            end
            default: nx_st = S_IGN;
          endcase
        end
        S_DATA: begin
          sreg_we = 1'b1;
          case (op_q)
            3'b100:  sreg_wd = cur | rx_byte;
            3'b101:  sreg_wd = cur & ~rx_byte;
            default: sreg_wd = rx_byte;
          endcase
          nx_st = S_IGN;
        end
        S_DUMMY: begin
          tx_ld = cur;
          nx_st = S_IGN;
        end
        S_BRD: begin
          tx_ld   = mem[ptr_nx];
          ptr_inc = 1'b1;
        end
        S_BWR: begin
          buf_we  = 1'b1;
          ptr_inc = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= 2'b11;
      sck_s  <= 3'b111;
      mosi_s <= 2'b00;
      st     <= S_CMD;
      bcnt   <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
      miso_q <= 1'b0;
      op_q   <= '0;
      arg_q  <= '0;
    end else begin
      cs_s   <= {cs_s[0], cs_n};
      sck_s  <= {sck_s[1:0], sck};
      mosi_s <= {mosi_s[0], mosi};
      if (!cs_act) begin
        st     <= S_CMD;
        bcnt   <= '0;
        tx_sh  <= '0;
        miso_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh <= rx_byte[6:0];
          bcnt  <= bcnt + 1'b1;
        end
        if (byte_done) begin
          st    <= nx_st;
          tx_sh <= tx_ld;
          if (st == S_CMD) begin
            op_q  <= rx_byte[7:5];
            arg_q <= rx_byte[4:0];
          end
        end else if (sck_fall) begin
          miso_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign w_en  = sreg_we | (int_we & int_reg);
  assign w_b   = sreg_we ? bank : int_addr[6:5];
  assign w_a   = sreg_we ? arg_q : int_addr[4:0];
  assign w_d   = sreg_we ? sreg_wd : int_wdata;
  assign w_eb  = (w_a >= A_COM) ? 2'd0 : w_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 32; a++) bank_r[b][a] <= '0;
      bank <= '0;
      ptr  <= '0;
    end else if (soft_rst) begin
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 32; a++) bank_r[b][a] <= '0;
      bank <= '0;
      ptr  <= '0;
    end else begin
      if (w_en) begin
        if (w_a == A_BANK)                      bank <= w_d[1:0];
        else if (w_a == A_STAT)                 begin end
        else if (w_eb == 2'd0 && w_a == A_PTRL) ptr[7:0] <= w_d;
        else if (w_eb == 2'd0 && w_a == A_PTRH) ptr[BUF_AW-1:8] <= w_d[PH_W-1:0];
        else                                    bank_r[w_eb][w_a] <= w_d;
      end
      if (ptr_inc) ptr <= ptr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (int_we && !int_reg) mem[int_addr] <= int_wdata;
    if (buf_we)             mem[ptr] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdy_cnt <= CW'(RDY_DLY);
    else if (soft_rst)       rdy_cnt <= CW'(RDY_DLY);
    else if (rdy_cnt != '0)  rdy_cnt <= rdy_cnt - 1'b1;
  end

  assign int_rdata = int_reg ? rd_reg(int_addr[6:5], int_addr[4:0]) : mem[int_addr];

endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int BUF_AW  = 11,
  parameter int RDY_DLY = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              miso,
  input logic              cs_act,
  input logic              byte_done,
  input logic              soft_rst,
  input logic              clk_rdy,
  input logic [1:0]        bank,
  input logic [BUF_AW-1:0] ptr,
  input logic [2:0]        st
);

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

  // R10
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (bank == 2'd0 && ptr == '0));

  // R10
  srst_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (RDY_DLY > 0 && soft_rst) |=> !clk_rdy);

  // R10
  srst_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> cs_act);

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == 3'd3 || st == 3'd4)) |=> ptr == BUF_AW'($past(ptr) + 1'b1));

  // R11
  idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (st == 3'd0));

endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.BUF_AW(BUF_AW), .RDY_DLY(RDY_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .cs_act(cs_act),
  .byte_done(byte_done), .soft_rst(soft_rst), .clk_rdy(clk_rdy),
  .bank(bank), .ptr(ptr), .st(st)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  localparam int AW  = 11;
  localparam int DLY = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b1, cs_n = 1'b1, mosi = 1'b0, miso;
  logic int_reg = 1'b0, int_we = 1'b0;
  logic [AW-1:0] int_addr = '0;
  logic [7:0] int_wdata = '0, int_rdata;

  int checks = 0, errors = 0;

  spi_cmd_slave #(.BUF_AW(AW), .RDY_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .int_reg(int_reg), .int_we(int_we), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata)
  );

  // fields: command, data, readback address, expected, requirement number
  localparam logic [39:0] VEC [11] = '{
    {8'h42, 8'h5A, 8'h02, 8'h5A, 8'd2},   // R2 R3
    {8'h82, 8'h81, 8'h02, 8'hDB, 8'd5},   // R5
    {8'hA2, 8'h0F, 8'h02, 8'hD0, 8'd6},   // R6
    {8'h5B, 8'h33, 8'h1B, 8'h33, 8'd4},   // R4 common register
    {8'h5F, 8'h01, 8'h02, 8'h00, 8'd4},   // R4 bank 1 is separate
    {8'h42, 8'h77, 8'h02, 8'h77, 8'd4},   // R4 write in bank 1
    {8'h9F, 8'h02, 8'h1F, 8'h03, 8'd4},   // R4 bank reg set -> bank 3
    {8'hBF, 8'h03, 8'h02, 8'hD0, 8'd4},   // R4 back to bank 0
    {8'h5D, 8'hFF, 8'h1D, 8'h01, 8'd12},  // R12 status write ignored
    {8'hBD, 8'h01, 8'h1D, 8'h01, 8'd12},  // R12 status clear ignored
    {8'hC2, 8'h00, 8'h02, 8'hD0, 8'd11}   // R11 unused opcode ignored
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; mosi = tx[i];
      tick(8);
      rx[i] = miso;
      sck = 1'b1;
      tick(8);
    end
  endtask

  task automatic cs_on;
    cs_n = 1'b0; tick(8);
  endtask

  task automatic cs_off;
    tick(8); cs_n = 1'b1; tick(8);
  endtask

  task automatic wr_cmd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    cs_on; xfer(c, r); xfer(d, r); cs_off;
  endtask

  task automatic rd_spi(input logic [4:0] a, input bit dummy, output logic [7:0] v);
    logic [7:0] r;
    cs_on; xfer({3'b000, a}, r);
    if (dummy) xfer(8'h00, r);
    xfer(8'h00, v); cs_off;
  endtask

  task automatic int_rd(input logic s, input logic [AW-1:0] a, output logic [7:0] v);
    int_reg = s; int_addr = a; #1; v = int_rdata;
    tick(1);
  endtask

  task automatic int_wr(input logic s, input logic [AW-1:0] a, input logic [7:0] d);
    int_reg = s; int_addr = a; int_wdata = d; int_we = 1'b1;
    tick(1);
    int_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, r;
    tick(5); rst_n = 1'b1; tick(4);

    // R1 reset state
    chk("R1 miso idle", {7'd0, miso}, 8'h00);
    int_rd(1'b1, 11'h01D, v); chk("R1 ready low", v, 8'h00);
    int_rd(1'b1, 11'h01F, v); chk("R1 bank zero", v, 8'h00);
    int_rd(1'b1, 11'h022, v); chk("R1 bank1 reg zero", v, 8'h00);
    tick(DLY + 16);
    int_rd(1'b1, 11'h01D, v); chk("R1 ready high", v, 8'h01);

    for (int i = 0; i < 11; i++) begin
      wr_cmd(VEC[i][39:32], VEC[i][31:24]);
      rd_spi(VEC[i][20:16], 1'b0, v);
      chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), v, VEC[i][15:8]);
    end

    // R7 R14 buffer read with wrap
    int_wr(1'b0, 11'h7FE, 8'hA1);
    int_wr(1'b0, 11'h7FF, 8'hB2);
    int_wr(1'b0, 11'h000, 8'hC3);
    wr_cmd(8'h40, 8'hFE);
    wr_cmd(8'h41, 8'h07);
    rd_spi(5'h01, 1'b0, v); chk("R14 pointer high", v, 8'h07);
    cs_on; xfer(8'h3A, r);
    xfer(8'h00, v); chk("R7 byte 0", v, 8'hA1);
    xfer(8'h00, v); chk("R7 byte 1", v, 8'hB2);
    xfer(8'h00, v); chk("R7 wrapped byte", v, 8'hC3);
    cs_off;
    rd_spi(5'h00, 1'b0, v); chk("R7 pointer low after wrap", v, 8'h01);
    rd_spi(5'h01, 1'b0, v); chk("R14 pointer high after wrap", v, 8'h00);

    // R8 buffer write
    wr_cmd(8'h40, 8'h10);
    cs_on; xfer(8'h7A, r); xfer(8'hD4, r); xfer(8'hE5, r); cs_off;
    int_rd(1'b0, 11'h010, v); chk("R8 first byte", v, 8'hD4);
    int_rd(1'b0, 11'h011, v); chk("R8 second byte", v, 8'hE5);
    rd_spi(5'h00, 1'b0, v); chk("R8 pointer advanced", v, 8'h12);

    // R13 internal register port with explicit bank
    int_rd(1'b1, 11'h022, v); chk("R13 bank1 addr 02", v, 8'h77);
    int_wr(1'b1, 11'h045, 8'h99);

    // R9 dummy byte in bank 2
    wr_cmd(8'h5F, 8'h02);
    cs_on; xfer(8'h05, r);
    xfer(8'h00, v); chk("R9 dummy byte", v, 8'h00);
    xfer(8'h00, v); chk("R9 data byte", v, 8'h99);
    cs_off;
    rd_spi(5'h1B, 1'b0, v); chk("R4 common from bank 2", v, 8'h33);

    // R11 extra bytes ignored, chip select ends command
    wr_cmd(8'h5F, 8'h00);
    cs_on; xfer(8'h43, r); xfer(8'h11, r); xfer(8'h22, r); cs_off;
    rd_spi(5'h03, 1'b0, v); chk("R11 extra byte ignored", v, 8'h11);

    // R10 soft reset
    cs_on; xfer(8'hFF, r); cs_off;
    int_rd(1'b1, 11'h01D, v); chk("R10 ready low", v, 8'h00);
    int_rd(1'b1, 11'h002, v); chk("R10 reg cleared", v, 8'h00);
    int_rd(1'b1, 11'h01B, v); chk("R10 common cleared", v, 8'h00);
    int_rd(1'b1, 11'h000, v); chk("R10 pointer cleared", v, 8'h00);
    int_rd(1'b0, 11'h010, v); chk("R10 buffer kept", v, 8'hD4);
    tick(DLY + 16);
    int_rd(1'b1, 11'h01D, v); chk("R10 ready again", v, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule